// File: doc/BRIEF.md
# Inter-processor interrupt controller

This block lets each of several processor cores signal any other core. Every core owns a pair of 32-bit registers on a small single-cycle register bus: a control word and a status word. Each core also has one interrupt output. A core posts a message by writing its own control word. The write carries a destination core, a 16-bit payload and command bits. The block works out who the sender is from the address that was written, so a core cannot pose as another.

The destination's status word then records the sender and the payload, and its interrupt line goes high. The receiving core reads its status word to learn who called and with what payload. It then writes its own control word with the acknowledge bit set, which drops its line. There is a single message slot per core: a newer message replaces an unread one.

Addresses are byte addresses with an 8-byte stride per core. Bit 2 picks the control word (0) or the status word (1). The bits from 3 upward give the core index, and bits 1:0 are ignored. Reads return data one cycle after the request, and the read data holds between reads.

Top module: `ipi_ctrl`

## Requirements
- R1: After reset every control and status word reads as 0, and all interrupt outputs and the read data are low.
- R2: A write to a core's control word (address bit 2 = 0) stores the whole 32-bit word. A read of that word returns it, one cycle after the read request. The read data keeps its value until the next read.
- R3: A control write with bit 30 set and a destination index (bits 29:16) below NUM_CORES loads the destination's status word. The loaded word has bit 30 = 1, bits 29:16 = the writer's index from the address, bits 15:0 = the written bits 15:0, and bit 31 = 0. The destination's interrupt output is high from the next cycle.
- R4: A control write with bit 31 set clears bit 30 of the writer's own status word and drops the writer's interrupt output from the next cycle. Bits 29:0 other than bit 30 keep their values.
- R5: A write to a status word (address bit 2 = 1) changes no register and no interrupt output.
- R6: A control write with bit 30 set and a destination index at or above NUM_CORES changes no status word and no interrupt output. The control word is still stored.
- R7: When one write sets both bit 30 and bit 31 and names the writer as destination, the new sender and payload are stored, the pending bit ends at 0 and the line is low. When the destination is another core, both commands take effect, each on its own core.
- R8: A newer message to a core replaces the sender and payload of an earlier one that was never acknowledged. There is no queue.
- R9: Each interrupt output always equals bit 30 of its core's status word. Without a bus write, no interrupt output changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address: bits 1:0 ignored, bit 2 control/status, upper bits core index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | NUM_CORES | Per-core interrupt level |

## Verification
The properties assume that a bus access is a single cycle with bus_wr stable for that cycle, and that read requests and writes never overlap. They also assume that the address and data are defined whenever bus_sel is high. The stimulus drives the bus only at falling clock edges, holds each access for exactly one cycle and never leaves bus_sel high across accesses. Random writes deliberately use destination indices above the core count. They also mix both command bits and hit both halves of each core's register pair, so the out-of-range, combined-command and ignored-write paths are covered alongside ordinary traffic.

// File: rtl/ipi_pkg.sv
// Package ipi_pkg: field layout of the per-core control and status words.
// Assumes 32-bit words; the field positions are part of the software contract.
package ipi_pkg;
    localparam int WORD_W    = 32;
    localparam int IDX_FLD_W = 14;
    localparam int PAYLOAD_W = 16;

    // Control word as written by a core.
    typedef struct packed {
        logic                 ack;
        logic                 gen;
        logic [IDX_FLD_W-1:0] dst;
        logic [PAYLOAD_W-1:0] payload;
    } ipi_ctrl_t;

    // Status word as seen by the receiving core.
    typedef struct packed {
        logic                 rsv;
        logic                 pend;
        logic [IDX_FLD_W-1:0] src;
        logic [PAYLOAD_W-1:0] payload;
    } ipi_stat_t;
endpackage

// File: rtl/ipi_decode.sv
// Module ipi_decode: turns one bus access into per-core strobes.
// Produces the control-store, message-delivery and acknowledge strobes,
// plus the read selection. Purely combinational. Assumes a single access per cycle.
module ipi_decode #(
    parameter int NUM_CORES = 1,
    parameter int IDX_W     = 1,
    parameter int ADDR_W    = 4
) (
    input  logic                           bus_sel,
    input  logic                           bus_wr,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [ipi_pkg::WORD_W-1:0]     bus_wdata,
    output logic [NUM_CORES-1:0]           ctrl_we,
    output logic [NUM_CORES-1:0]           gen_hit,
    output logic [NUM_CORES-1:0]           ack_hit,
    output logic [ipi_pkg::IDX_FLD_W-1:0]  msg_src,
    output logic [ipi_pkg::PAYLOAD_W-1:0]  msg_payload,
    output logic                           rd_en,
    output logic                           rd_stat,
    output logic [IDX_W-1:0]               rd_idx,
    output logic                           rd_ok
);
    import ipi_pkg::*;

    logic [IDX_W-1:0] core_idx;
    logic             reg_is_stat;
    logic             idx_ok;
    logic             wr_ctrl;
    logic             dst_ok;
    ipi_ctrl_t        cw;
    logic             unused_addr_lsb;

    // Split the address and the written word into their fields.
    always_comb begin
        core_idx    = bus_addr[ADDR_W-1:3];
        reg_is_stat = bus_addr[2];
        idx_ok      = {{(32-IDX_W){1'b0}}, core_idx} < NUM_CORES;
        cw          = ipi_ctrl_t'(bus_wdata);
        wr_ctrl     = bus_sel && bus_wr && !reg_is_stat && idx_ok;
        dst_ok      = {{(32-IDX_FLD_W){1'b0}}, cw.dst} < NUM_CORES;
        msg_src     = IDX_FLD_W'(core_idx);
        msg_payload = cw.payload;
        rd_en       = bus_sel && !bus_wr;
        rd_stat     = reg_is_stat;
        rd_idx      = core_idx;
        rd_ok       = idx_ok;
    end

    assign unused_addr_lsb = ^bus_addr[1:0];

    // One set of strobes per core slot.
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_strobe
        localparam logic [IDX_W-1:0]     MY_IDX = IDX_W'(i);
        localparam logic [IDX_FLD_W-1:0] MY_DST = IDX_FLD_W'(i);
        assign ctrl_we[i] = wr_ctrl && (core_idx == MY_IDX);
        assign gen_hit[i] = wr_ctrl && cw.gen && dst_ok && (cw.dst == MY_DST);
        assign ack_hit[i] = wr_ctrl && cw.ack && (core_idx == MY_IDX);
    end
endmodule

// File: rtl/ipi_slot.sv
// Module ipi_slot: one core's control word, status word and interrupt level.
// A delivered message is applied first and an acknowledge second, so a
// self-addressed message with acknowledge ends not pending.
module ipi_slot (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ctrl_we,
    input  logic [ipi_pkg::WORD_W-1:0]    wdata,
    input  logic                          gen_hit,
    input  logic [ipi_pkg::IDX_FLD_W-1:0] gen_src,
    input  logic [ipi_pkg::PAYLOAD_W-1:0] gen_payload,
    input  logic                          ack_hit,
    output logic [ipi_pkg::WORD_W-1:0]    ctrl_q,
    output logic [ipi_pkg::WORD_W-1:0]    stat_q,
    output logic                          irq
);
    import ipi_pkg::*;

    ipi_stat_t stat_r;
    ipi_stat_t stat_d;

    // Next status: message load, then acknowledge.
    always_comb begin
        stat_d = stat_r;
        if (gen_hit) begin
            stat_d.rsv     = 1'b0;
            stat_d.pend    = 1'b1;
            stat_d.src     = gen_src;
            stat_d.payload = gen_payload;
        end
        if (ack_hit) begin
            stat_d.pend = 1'b0;
        end
    end

    // Register the control word and the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            stat_r <= '0;
        end else begin
            if (ctrl_we) begin
                ctrl_q <= wdata;
            end
            stat_r <= stat_d;
        end
    end

    assign stat_q = stat_r;
    assign irq    = stat_r.pend;
endmodule

// File: rtl/ipi_readmux.sv
// Module ipi_readmux: registered read port over all cores' words.
// An index beyond the core count reads as zero. The data holds between reads.
module ipi_readmux #(
    parameter int NUM_CORES = 1,
    parameter int IDX_W     = 1
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   rd_en,
    input  logic                                   rd_stat,
    input  logic [IDX_W-1:0]                       rd_idx,
    input  logic                                   rd_ok,
    input  logic [NUM_CORES-1:0][ipi_pkg::WORD_W-1:0] ctrl_all,
    input  logic [NUM_CORES-1:0][ipi_pkg::WORD_W-1:0] stat_all,
    output logic [ipi_pkg::WORD_W-1:0]             rdata
);
    import ipi_pkg::*;

    logic [WORD_W-1:0] pick;

    // Select the addressed word.
    always_comb begin
        pick = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (rd_ok && rd_idx == IDX_W'(i)) begin
                pick = rd_stat ? stat_all[i] : ctrl_all[i];
            end
        end
    end

    // Capture the selection on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= pick;
        end
    end
endmodule

// File: rtl/ipi_ctrl.sv
// Module ipi_ctrl: inter-processor interrupt controller, top level.
// Single-cycle register bus with one access per cycle and an 8-byte stride
// per core. Assumes a synchronous active-low reset.
module ipi_ctrl #(
    parameter int NUM_CORES = 1,
    localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int ADDR_W   = IDX_W + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_CORES-1:0] irq_o
);
    import ipi_pkg::*;

    logic [NUM_CORES-1:0]             ctrl_we;
    logic [NUM_CORES-1:0]             gen_hit;
    logic [NUM_CORES-1:0]             ack_hit;
    logic [IDX_FLD_W-1:0]             msg_src;
    logic [PAYLOAD_W-1:0]             msg_payload;
    logic                             rd_en;
    logic                             rd_stat;
    logic [IDX_W-1:0]                 rd_idx;
    logic                             rd_ok;
    logic [NUM_CORES-1:0][WORD_W-1:0] ctrl_all;
    logic [NUM_CORES-1:0][WORD_W-1:0] stat_all;

    ipi_decode #(
        .NUM_CORES (NUM_CORES),
        .IDX_W     (IDX_W),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .ctrl_we     (ctrl_we),
        .gen_hit     (gen_hit),
        .ack_hit     (ack_hit),
        .msg_src     (msg_src),
        .msg_payload (msg_payload),
        .rd_en       (rd_en),
        .rd_stat     (rd_stat),
        .rd_idx      (rd_idx),
        .rd_ok       (rd_ok)
    );

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_slot
        ipi_slot u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .ctrl_we     (ctrl_we[i]),
            .wdata       (bus_wdata),
            .gen_hit     (gen_hit[i]),
            .gen_src     (msg_src),
            .gen_payload (msg_payload),
            .ack_hit     (ack_hit[i]),
            .ctrl_q      (ctrl_all[i]),
            .stat_q      (stat_all[i]),
            .irq         (irq_o[i])
        );
    end

    ipi_readmux #(
        .NUM_CORES (NUM_CORES),
        .IDX_W     (IDX_W)
    ) u_readmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_stat  (rd_stat),
        .rd_idx   (rd_idx),
        .rd_ok    (rd_ok),
        .ctrl_all (ctrl_all),
        .stat_all (stat_all),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/ipi_ctrl_chk.sv
// Module ipi_ctrl_chk: port-level properties of ipi_ctrl, attached by bind.
// Assumes one bus access per cycle and defined address and data under bus_sel.
module ipi_ctrl_chk #(
    parameter int NUM_CORES = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic [((NUM_CORES > 1) ? $clog2(NUM_CORES) : 1) + 2:0] bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NUM_CORES-1:0] irq_o
);
    localparam int IDX_W  = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
    localparam int ADDR_W = IDX_W + 3;

    logic [IDX_W-1:0] core;
    logic [13:0]      dst;
    logic             in_rng;
    logic             dst_ok;
    logic             wr_ctrl;
    logic             wr_stat;
    logic             self_both;
    logic [IDX_W-1:0] src_q;
    logic [IDX_W-1:0] dst_q;
    logic             unused_bits;

    // Decode the observed access.
    always_comb begin
        core      = bus_addr[ADDR_W-1:3];
        dst       = bus_wdata[29:16];
        in_rng    = {{(32-IDX_W){1'b0}}, core} < NUM_CORES;
        dst_ok    = {18'b0, dst} < NUM_CORES;
        wr_ctrl   = bus_sel && bus_wr && !bus_addr[2] && in_rng;
        wr_stat   = bus_sel && bus_wr && bus_addr[2];
        self_both = bus_wdata[31] && (dst[IDX_W-1:0] == core);
    end

    assign unused_bits = ^{bus_addr[1:0], bus_wdata[15:0]};

    // Remember the last writer and destination for next-cycle checks.
    always_ff @(posedge clk) begin
        src_q <= core;
        dst_q <= dst[IDX_W-1:0];
    end

    // R3
    gen_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[30] && dst_ok && !self_both) |=> irq_o[dst_q]);

    // R4
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[31]) |=> !irq_o[src_q]);

    // R5
    stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> $stable(irq_o));

    // R6
    bad_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[30] && !dst_ok && !bus_wdata[31]) |=> $stable(irq_o));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> $stable(irq_o));

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
endmodule

bind ipi_ctrl ipi_ctrl_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
);

// File: tb/ipi_ctrl_bench.sv
// Bench for ipi_ctrl with four cores: directed cases, then seeded random writes.
module ipi_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NC         = 4;
    localparam int AW         = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] irq_o;

    int n_run  = 0;
    int n_fail = 0;

    logic [31:0] m_ctrl [NC];
    logic [31:0] m_stat [NC];

    ipi_ctrl #(.NUM_CORES(NC)) u_ipi_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [AW-1:0] mk_addr(int core, int is_stat);
        return {core[1:0], is_stat[0], 2'b00};
    endfunction

    function automatic logic [NC-1:0] exp_irq();
        logic [NC-1:0] v;
        for (int i = 0; i < NC; i++) v[i] = m_stat[i][30];
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Model of one write, written from the requirements.
    task automatic model_write(int core, int is_stat, logic [31:0] d);
        int dst;
        if (is_stat != 0) return;
        m_ctrl[core] = d;
        dst = int'(d[29:16]);
        if (d[30] && dst < NC) m_stat[dst] = {2'b01, 14'(core), d[15:0]};
        if (d[31]) m_stat[core][30] = 1'b0;
    endtask

    task automatic bus_write(int core, int is_stat, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1;
        bus_addr = mk_addr(core, is_stat) | AW'($urandom_range(0, 3));
        bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        model_write(core, is_stat, d);
    endtask

    task automatic bus_read(int core, int is_stat, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0;
        bus_addr = mk_addr(core, is_stat);
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic check_read(string req, int core, int is_stat);
        logic [31:0] d;
        bus_read(core, is_stat, d);
        check(req, d, is_stat != 0 ? m_stat[core] : m_ctrl[core]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h1bad5eed));
        for (int i = 0; i < NC; i++) begin m_ctrl[i] = '0; m_stat[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", 32'(irq_o), 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        for (int c = 0; c < NC; c++) begin
            check_read("R1", c, 0);
            check_read("R1", c, 1);
        end

        // R2 control store and read-back, data holds between reads
        bus_write(1, 0, 32'h1234_5678);
        check_read("R2", 1, 0);
        repeat (3) @(negedge clk);
        check("R2 hold", bus_rdata, 32'h1234_5678);

        // R3 message from core 2 to core 0
        bus_write(2, 0, 32'h4000_BEEF);
        check("R3 irq", 32'(irq_o), 32'h1);
        bus_read(0, 1, d);
        check("R3 status", d, 32'h4002_BEEF);

        // R8 newer message from core 3 overwrites
        bus_write(3, 0, 32'h4000_0001);
        bus_read(0, 1, d);
        check("R8 status", d, 32'h4003_0001);

        // R4 core 0 acknowledges
        bus_write(0, 0, 32'h8000_0000);
        check("R4 irq", 32'(irq_o), 32'h0);
        bus_read(0, 1, d);
        check("R4 status", d, 32'h0003_0001);

        // R5 status writes ignored
        bus_write(1, 1, 32'hFFFF_FFFF);
        check("R5 irq", 32'(irq_o), 32'h0);
        bus_read(1, 1, d);
        check("R5 status", d, 32'h0);
        check_read("R5 ctrl", 1, 0);

        // R6 destination beyond core count
        bus_write(1, 0, 32'h4007_0055);
        check("R6 irq", 32'(irq_o), 32'h0);
        bus_read(1, 0, d);
        check("R6 ctrl", d, 32'h4007_0055);
        for (int c = 0; c < NC; c++) check_read("R6 status", c, 1);

        // R7 self message with acknowledge, then to another core with acknowledge
        bus_write(2, 0, 32'hC002_00AA);
        check("R7 irq", 32'(irq_o), 32'h0);
        bus_read(2, 1, d);
        check("R7 status", d, 32'h0002_00AA);
        bus_write(1, 0, 32'h4003_0777);
        bus_write(3, 0, 32'hC001_0042);
        check("R7 cross irq", 32'(irq_o), 32'h2);
        bus_read(1, 1, d);
        check("R7 cross status", d, 32'h4003_0042);

        // R9 random traffic: outputs track the model's pending bits
        for (int n = 0; n < 400; n++) begin
            logic [31:0] w;
            int dst;
            dst = $urandom_range(0, 6);
            w = {$urandom_range(0, 3) == 0 ? 1'b1 : 1'b0,
                 $urandom_range(0, 2) != 0 ? 1'b1 : 1'b0,
                 14'(dst), 16'($urandom)};
            bus_write($urandom_range(0, NC - 1), $urandom_range(0, 4) == 0 ? 1 : 0, w);
            check("R9 irq", 32'(irq_o), 32'(exp_irq()));
            check_read("R9 read", $urandom_range(0, NC - 1), $urandom_range(0, 1));
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule